// File: doc/BRIEF.md
# SDRAM Command Timing Guard

This block sits between an SDRAM command sequencer and the memory pins of a single bank. The sequencer presents one encoded request per cycle: activate, read, write, precharge, refresh, or clock-enable rise (leaving self-refresh). The guard keeps one down-counter for each inter-command delay. It raises `req_accept` in the first cycle in which every delay that applies to the presented command has run out. In that same cycle it reloads the counters that the accepted command starts.

The delays are programmed through a small register write port and can be read back one cycle later. Each delay in whole cycles is forced up to a two-cycle minimum. The self-refresh exit delay is given in half cycles and is rounded up to whole cycles. The CAS latency register accepts only the two-cycle code.

Top module: `sdram_cmd_guard`

## Requirements
- R1: After reset the registers read back: address 0 (write recovery) = 2, 1 (row cycle) = 8, 2 (row precharge) = 3, 3 (activate to read/write) = 3, 4 (activate to precharge) = 5, 5 (self-refresh exit, half cycles) = 10, 6 (CAS latency) = 2'b10. A read presents `cfg_addr` and sees `cfg_rdata` after the next clock edge.
- R2: A read or write is accepted no sooner than D cycles after the last accepted activate, where D is the clamped value of register 3.
- R3: A precharge is accepted no sooner than D cycles after the last accepted activate, where D is the clamped value of register 4.
- R4: After an accepted precharge, no command of any kind is accepted for D cycles, where D is the clamped value of register 2.
- R5: An activate is accepted no sooner than D cycles after the last accepted refresh, where D is the clamped value of register 1.
- R6: A precharge is accepted no sooner than D cycles after the last accepted write, where D is the clamped value of register 0.
- R7: A delay register (addresses 0 to 4, 4 bits each) holding 0, 1 or 2 gives a two-cycle wait. Values 3 to 15 give that many cycles.
- R8: The self-refresh exit register (address 5, 5 bits) holds half cycles, h. An activate waits max(1, ceil(h/2)) cycles after an accepted clock-enable rise. So 0 and 1 give 1 cycle, 3 gives 2 cycles and 31 gives 16 cycles.
- R9: A write to register 6 of any code other than 2'b10 is ignored, and the register keeps reading back 2'b10.
- R10: Command codes are 1 activate, 2 read, 3 write, 4 precharge, 5 refresh, 6 clock-enable rise. Codes 0 and 7 are never accepted. A request is accepted only when `req_valid` is high and in the first cycle in which all of its delays are spent; until then `req_accept` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address for write and read |
| cfg_wdata | input | 5 | Register write data |
| cfg_rdata | output | 5 | Registered read data for the previous cycle's `cfg_addr` |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 3 | Command code of the request |
| req_accept | output | 1 | The request is issued in this cycle |

## Verification
The bench goes after the clamp boundary by programming 0, 1, 2 and 15 into each whole-cycle delay. A design with an off-by-one clamp would issue commands one cycle early or late, and the measured gaps would show it. It checks the self-refresh exit rounding at 0, 1, 2, 3, 10 and 31 half cycles, where truncating instead of rounding up would shorten odd values by a cycle. It checks that write recovery counts from the last of several writes, not the first. It also checks that a reserved CAS code leaves the register unchanged. A behavioural model predicts `req_accept` every cycle, so a request that is held one cycle too long, or let through one cycle early, is caught where it happens.

// File: rtl/sdg_pkg.sv
package sdg_pkg;
  localparam int DLY_W  = 4;
  localparam int XSR_W  = 5;
  localparam int CAS_W  = 2;
  localparam int CFG_AW = 3;
  localparam int CFG_DW = 5;
  localparam int NCTR   = 6;

  // counter slots
  localparam int C_WREC = 0;
  localparam int C_RCYC = 1;
  localparam int C_RPRE = 2;
  localparam int C_A2C  = 3;
  localparam int C_A2P  = 4;
  localparam int C_SRX  = 5;

  // register addresses
  localparam logic [CFG_AW-1:0] A_WREC = 3'd0;
  localparam logic [CFG_AW-1:0] A_RCYC = 3'd1;
  localparam logic [CFG_AW-1:0] A_RPRE = 3'd2;
  localparam logic [CFG_AW-1:0] A_A2C  = 3'd3;
  localparam logic [CFG_AW-1:0] A_A2P  = 3'd4;
  localparam logic [CFG_AW-1:0] A_SRX  = 3'd5;
  localparam logic [CFG_AW-1:0] A_CAS  = 3'd6;

  localparam logic [CAS_W-1:0] CAS_TWO = 2'b10;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5,
    CMD_CKE  = 3'd6,
    CMD_BAD  = 3'd7
  } cmd_e;

  // programmed cycles -> counter reload, with two-cycle floor
  function automatic logic [DLY_W-1:0] clamp_load(input logic [DLY_W-1:0] v);
    return (v <= DLY_W'(2)) ? DLY_W'(1) : v - DLY_W'(1);
  endfunction

  // half cycles -> counter reload, rounded up, minimum one cycle
  function automatic logic [DLY_W-1:0] srx_load(input logic [XSR_W-1:0] h);
    return (h == '0) ? '0 : h[XSR_W-1:1] - DLY_W'(!h[0]);
  endfunction
endpackage

// File: rtl/sdg_cfg_regs.sv
module sdg_cfg_regs
  import sdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  output logic [CFG_DW-1:0] rdata,
  output logic [DLY_W-1:0]  wr_rec,
  output logic [DLY_W-1:0]  row_cyc,
  output logic [DLY_W-1:0]  row_pre,
  output logic [DLY_W-1:0]  act2col,
  output logic [DLY_W-1:0]  act2pre,
  output logic [XSR_W-1:0]  sr_exit,
  output logic [CAS_W-1:0]  cas_lat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_rec  <= DLY_W'(2);
      row_cyc <= DLY_W'(8);
      row_pre <= DLY_W'(3);
      act2col <= DLY_W'(3);
      act2pre <= DLY_W'(5);
      sr_exit <= XSR_W'(10);
      cas_lat <= CAS_TWO;
    end else if (we) begin
      case (addr)
        A_WREC: wr_rec  <= wdata[DLY_W-1:0];
        A_RCYC: row_cyc <= wdata[DLY_W-1:0];
        A_RPRE: row_pre <= wdata[DLY_W-1:0];
        A_A2C:  act2col <= wdata[DLY_W-1:0];
        A_A2P:  act2pre <= wdata[DLY_W-1:0];
        A_SRX:  sr_exit <= wdata[XSR_W-1:0];
        A_CAS:  if (wdata[CAS_W-1:0] == CAS_TWO) cas_lat <= wdata[CAS_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        A_WREC:  rdata <= CFG_DW'(wr_rec);
        A_RCYC:  rdata <= CFG_DW'(row_cyc);
        A_RPRE:  rdata <= CFG_DW'(row_pre);
        A_A2C:   rdata <= CFG_DW'(act2col);
        A_A2P:   rdata <= CFG_DW'(act2pre);
        A_SRX:   rdata <= CFG_DW'(sr_exit);
        A_CAS:   rdata <= CFG_DW'(cas_lat);
        default: rdata <= '0;
      endcase
    end
  end

  // R9: reserved latency codes never land in the register
  p_cas_fixed_r9: assert property (@(posedge clk) disable iff (rst)
    cas_lat == CAS_TWO);
endmodule

// File: rtl/sdg_delay_ctr.sv
module sdg_delay_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign busy = (cnt != '0);

  // R10: a running wait shrinks by exactly one per cycle
  p_count_down_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> (cnt == $past(cnt) - W'(1)));

  // R10: an expired wait stays expired until reloaded
  p_stay_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !load) |=> !busy);
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  output logic              req_accept
);
  logic [DLY_W-1:0] wr_rec, row_cyc, row_pre, act2col, act2pre;
  logic [XSR_W-1:0] sr_exit;
  logic [CAS_W-1:0] cas_lat;

  sdg_cfg_regs u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .wr_rec(wr_rec), .row_cyc(row_cyc), .row_pre(row_pre),
    .act2col(act2col), .act2pre(act2pre), .sr_exit(sr_exit), .cas_lat(cas_lat)
  );

  cmd_e             cmd;
  logic             known;
  logic [NCTR-1:0]  need, busy, ld;
  logic [DLY_W-1:0] ld_val [NCTR];

  assign cmd = cmd_e'(req_cmd);

  always_comb begin
    need  = '0;
    known = 1'b1;
    case (cmd)
      CMD_ACT: begin need[C_RPRE] = 1'b1; need[C_RCYC] = 1'b1; need[C_SRX] = 1'b1; end
      CMD_RD, CMD_WR: begin need[C_RPRE] = 1'b1; need[C_A2C] = 1'b1; end
      CMD_PRE: begin need[C_RPRE] = 1'b1; need[C_A2P] = 1'b1; need[C_WREC] = 1'b1; end
      CMD_REF, CMD_CKE: need[C_RPRE] = 1'b1;
      default: known = 1'b0;
    endcase
  end

  assign req_accept = !rst && req_valid && known && ((busy & need) == '0);

  always_comb begin
    ld         = '0;
    ld[C_WREC] = req_accept && (cmd == CMD_WR);
    ld[C_RCYC] = req_accept && (cmd == CMD_REF);
    ld[C_RPRE] = req_accept && (cmd == CMD_PRE);
    ld[C_A2C]  = req_accept && (cmd == CMD_ACT);
    ld[C_A2P]  = req_accept && (cmd == CMD_ACT);
    ld[C_SRX]  = req_accept && (cmd == CMD_CKE);
  end

  assign ld_val[C_WREC] = clamp_load(wr_rec);
  assign ld_val[C_RCYC] = clamp_load(row_cyc);
  assign ld_val[C_RPRE] = clamp_load(row_pre);
  assign ld_val[C_A2C]  = clamp_load(act2col);
  assign ld_val[C_A2P]  = clamp_load(act2pre);
  assign ld_val[C_SRX]  = srx_load(sr_exit);

  for (genvar g = 0; g < NCTR; g++) begin : g_ctr
    sdg_delay_ctr #(.W(DLY_W)) u_ctr (
      .clk(clk), .rst(rst), .load(ld[g]), .load_val(ld_val[g]), .busy(busy[g])
    );
  end

  // R4: nothing issues in the cycle right after a precharge
  p_pre_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (req_accept && cmd == CMD_PRE) |=> !req_accept);

  // R7: column and precharge commands never follow an activate back to back
  p_act_floor_r7: assert property (@(posedge clk) disable iff (rst)
    (req_accept && cmd == CMD_ACT) |=>
      !(req_accept && (cmd == CMD_RD || cmd == CMD_WR || cmd == CMD_PRE)));

  // R5: an activate never directly follows a refresh
  p_ref_act_r5: assert property (@(posedge clk) disable iff (rst)
    (req_accept && cmd == CMD_REF) |=> !(req_accept && cmd == CMD_ACT));

  // R6: a precharge never directly follows a write
  p_wr_pre_r6: assert property (@(posedge clk) disable iff (rst)
    (req_accept && cmd == CMD_WR) |=> !(req_accept && cmd == CMD_PRE));
endmodule

// File: tb/sdram_cmd_guard_bench.sv
module sdram_cmd_guard_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [4:0] cfg_wdata = '0;
  logic [4:0] cfg_rdata;
  logic       req_valid = 1'b0;
  logic [2:0] req_cmd = '0;
  logic       req_accept;

  always #5 clk = ~clk;

  sdram_cmd_guard u_sdram_cmd_guard (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_accept(req_accept)
  );

  int ncmp = 0, nbad = 0, cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model: raw register values and cycle of last start per delay
  int cfgv [7] = '{2, 8, 3, 3, 5, 10, 2};
  int last [6] = '{-1000, -1000, -1000, -1000, -1000, -1000};

  function automatic int dly(int i);
    if (i == 5) return (cfgv[5] == 0) ? 1 : (cfgv[5] + 1) / 2;
    return (cfgv[i] <= 2) ? 2 : cfgv[i];
  endfunction

  function automatic bit spent(int i);
    return (cyc - last[i]) >= dly(i);
  endfunction

  function automatic bit may_go(int c);
    case (c)
      1: return spent(2) && spent(1) && spent(5);
      2, 3: return spent(2) && spent(3);
      4: return spent(2) && spent(4) && spent(0);
      5, 6: return spent(2);
      default: return 0;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    ncmp++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic note_start(int c);
    case (c)
      1: begin last[3] = cyc; last[4] = cyc; end
      3: last[0] = cyc;
      4: last[2] = cyc;
      5: last[1] = cyc;
      6: last[5] = cyc;
      default: ;
    endcase
  endtask

  // one cycle: compare accept against the model, then move to next negedge
  task automatic step();
    bit exp;
    #1;
    exp = req_valid && may_go(int'(req_cmd));
    chk("R10 per-cycle accept", int'(req_accept), int'(exp));
    if (exp) note_start(int'(req_cmd));
    @(negedge clk);
  endtask

  task automatic idle(int n);
    req_valid = 0;
    repeat (n) step();
  endtask

  task automatic send(int c, output int t);
    bit got = 0;
    t = -1;
    req_valid = 1;
    req_cmd = 3'(c);
    for (int k = 0; k < 40 && !got; k++) begin
      #1;
      if (may_go(c)) begin got = 1; t = cyc; end
      chk("R10 per-cycle accept", int'(req_accept), int'(got));
      if (got) note_start(c);
      @(negedge clk);
    end
    req_valid = 0;
  endtask

  task automatic wr_cfg(int a, int d);
    cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 5'(d);
    step();
    cfg_we = 0;
    if (a == 6) begin
      if ((d & 3) == 2) cfgv[6] = 2;
    end else if (a == 5) cfgv[5] = d & 31;
    else cfgv[a] = d & 15;
  endtask

  task automatic rd_cfg(int a, int exp, string tag);
    cfg_we = 0; cfg_addr = 3'(a);
    step();
    chk(tag, int'(cfg_rdata), exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  initial begin
    int t1, t2, t3, t4, t5, t6, t7;
    int hv [6] = '{0, 1, 2, 3, 10, 31};
    int hx [6] = '{1, 1, 1, 2, 5, 16};
    repeat (3) @(negedge clk);
    rst = 0;

    // R1: reset values
    rd_cfg(0, 2, "R1 reset wr_rec");
    rd_cfg(1, 8, "R1 reset row_cyc");
    rd_cfg(2, 3, "R1 reset row_pre");
    rd_cfg(3, 3, "R1 reset act2col");
    rd_cfg(4, 5, "R1 reset act2pre");
    rd_cfg(5, 10, "R1 reset sr_exit");
    rd_cfg(6, 2, "R1 reset cas");
    idle(5);

    // defaults
    send(1, t1); send(2, t2);
    chk("R2 act->rd default", t2 - t1, 3);
    send(4, t3);
    chk("R3 act->pre default", t3 - t1, 5);
    send(1, t4);
    chk("R4 pre->act default", t4 - t3, 3);

    // clamp floor with 0, 1, 2
    idle(20);
    wr_cfg(0, 0); wr_cfg(1, 1); wr_cfg(2, 2); wr_cfg(3, 0); wr_cfg(4, 1);
    idle(2);
    send(1, t1); send(3, t2);
    chk("R7 act->wr with 0", t2 - t1, 2);
    send(4, t3);
    chk("R7 wr->pre with 0", t3 - t2, 2);
    send(1, t4);
    chk("R7 pre->act with 2", t4 - t3, 2);
    send(5, t5); send(1, t6);
    chk("R7 ref->act with 1", t6 - t5, 2);
    send(4, t7);
    chk("R7 act->pre with 1", t7 - t6, 2);

    // maximum values
    idle(20);
    for (int a = 0; a < 5; a++) wr_cfg(a, 15);
    rd_cfg(3, 15, "R1 readback 15");
    idle(20);
    send(1, t1); send(2, t2);
    chk("R2 act->rd 15", t2 - t1, 15);
    send(3, t3); send(4, t4);
    chk("R6 wr->pre 15", t4 - t3, 15);
    send(1, t5);
    chk("R4 pre->act 15", t5 - t4, 15);
    send(5, t6); send(1, t7);
    chk("R5 ref->act 15", t7 - t6, 15);
    send(4, t1);
    chk("R3 act->pre 15", t1 - t7, 15);

    // write recovery counts from the last write
    idle(20);
    send(1, t1); send(3, t2); idle(5); send(3, t3); send(4, t4);
    chk("R6 last wr->pre", t4 - t3, 15);

    // self-refresh exit rounding
    for (int i = 0; i < 6; i++) begin
      idle(20);
      wr_cfg(5, hv[i]);
      idle(2);
      send(6, t1); send(1, t2);
      chk($sformatf("R8 exit h=%0d", hv[i]), t2 - t1, hx[i]);
    end

    // latency codes
    wr_cfg(6, 1); rd_cfg(6, 2, "R9 cas after 01");
    wr_cfg(6, 0); rd_cfg(6, 2, "R9 cas after 00");
    wr_cfg(6, 3); rd_cfg(6, 2, "R9 cas after 11");
    wr_cfg(6, 2); rd_cfg(6, 2, "R9 cas after 10");

    // unknown codes never accepted
    idle(20);
    req_valid = 1; req_cmd = 3'd0;
    for (int k = 0; k < 3; k++) begin #1; chk("R10 code 0 held", int'(req_accept), 0); @(negedge clk); end
    req_cmd = 3'd7;
    for (int k = 0; k < 3; k++) begin #1; chk("R10 code 7 held", int'(req_accept), 0); @(negedge clk); end
    req_valid = 0;
    idle(3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule